// File: doc/BRIEF.md
# Multiplexed Sigma-Delta Converter Readout Sequencer

This block sits on the host side of a slow sigma-delta converter that has an eight-way analog input switch in front of it. The converter drives its own serial clock in this mode. The host watches that clock and the converter's data line, and it owns two select lines: one for the converter and one, always the opposite level, for the input switch. While the host clocks in one conversion word, it uses the same serial clock edges to send the switch a four-bit word that picks the channel for the following conversion. That choice takes effect when the converter select goes high.

Both lines from the converter are brought into the host clock through a synchronizer chain. Rising clock edges are then found on the synchronized copy. A read starts once the data line is seen low while the converter is selected, which means the conversion has ended. The read counts a requested number of rising edges, from 1 to 32. After the last counted edge, the host raises the converter select while the serial clock is still high. This ends the readout (or cuts it short) and starts the next conversion. The captured fields and the channel that the word belongs to come out with a one-cycle valid strobe.

Top module: `adc_mux_reader`

## Requirements
- R1: While reset is high and in the first cycle after it, `adc_cs_o` is 0, `mux_cs_o` is 1, `mux_din_o` is 0 and `res_valid_o` is 0.
- R2: A read starts only when the synchronized data line is low while `adc_cs_o` is 0. `chan_req_i`, `chan_en_i` and `rd_len_i` are sampled in that start cycle, and later changes have no effect on that read.
- R3: The k-th counted rising serial clock edge (k = 1..32) stores the data line into word bit 32-k. Bit 31 is the end-of-conversion flag, bit 30 the test bit, bit 29 the sign, bit 28 the range flag and bits 27..0 the magnitude.
- R4: `rd_len_i` gives the number of edges read. A value of 0 or above 32 means 32. In the cycle after the last counted edge is detected, `adc_cs_o` rises while the synchronized clock is high. It stays high for CS_HIGH_CYC cycles (default 4) and then falls. It never rises during a low clock phase.
- R5: `res_valid_o` is a single-cycle pulse in the same cycle that `adc_cs_o` rises. It presents the word fields of R3. Bits not received read 0, and `res_trunc_o` is 1 exactly when fewer than 32 bits were read.
- R6: When the switch is programmed, `mux_din_o` carries 1 before the 1st counted edge, then channel bits 2, 1 and 0 before edges 2, 3 and 4. It is 0 before every later edge and whenever `adc_cs_o` is 1.
- R7: `mux_cs_o` is always the inverse of `adc_cs_o`.
- R8: If `chan_en_i` is 0 or the effective length is below 4 at the start of a read, `mux_din_o` stays 0 for that whole read and the switch channel is left unchanged.
- R9: `res_chan_o` is the channel in force during the conversion being read. That is the channel programmed by the last read that programmed one, or 0 after reset.
- R10: Between strobes, all result outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_sck_i | input | 1 | Serial clock driven by the converter |
| adc_sdo_i | input | 1 | Converter serial data, low = conversion done |
| chan_req_i | input | 3 | Channel wanted for the next conversion |
| chan_en_i | input | 1 | 1 = program the channel during this read |
| rd_len_i | input | 6 | Number of bits to read (0 or >32 means 32) |
| adc_cs_o | output | 1 | Converter select, active low |
| mux_cs_o | output | 1 | Input switch select, inverse of adc_cs_o |
| mux_din_o | output | 1 | Serial data to the input switch |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_eoc_o | output | 1 | Captured end-of-conversion flag |
| res_test_o | output | 1 | Captured test bit |
| res_sign_o | output | 1 | Captured sign bit |
| res_range_o | output | 1 | Captured extended-range flag |
| res_data_o | output | 28 | Captured magnitude, MSB first, unreceived bits 0 |
| res_chan_o | output | 3 | Channel the result was converted on |
| res_trunc_o | output | 1 | 1 when the read was shorter than 32 bits |

## Verification
A raw serial clock rise reaches the block's outputs three host cycles later: two synchronizer flops, then the output register. At that point the select rises and the strobe fires together, and the select then stays high for CS_HIGH_CYC cycles. The bench model holds every serial clock level for eight host cycles, so every reaction falls inside the same phase that caused it. All outputs are polled on falling host clock edges. The bench samples the switch data at the instant it raises the serial clock, which is before the block can react. It counts the strobe cycles and the select-high cycles instead of assuming fixed offsets, and it compares them against the counts the requirements give.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int WORD_W    = 32;
    localparam int CNT_W     = $clog2(WORD_W + 1);
    localparam int CHAN_W    = 3;
    localparam int MUX_W     = CHAN_W + 1;
    localparam int HDR_W     = 4;
    localparam int DATA_W    = WORD_W - HDR_W;
    localparam int POS_EOC   = WORD_W - 1;
    localparam int POS_TEST  = WORD_W - 2;
    localparam int POS_SIGN  = WORD_W - 3;
    localparam int POS_RANGE = WORD_W - 4;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_READ = 2'd1,
        ST_HOLD = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic              eoc;
        logic              test;
        logic              sign;
        logic              range_ovr;
        logic [DATA_W-1:0] data;
        logic [CHAN_W-1:0] chan;
        logic              trunc;
    } rd_result_t;

    // Requested length mapped to 1..WORD_W
    function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] req);
        if (req == '0 || req > CNT_W'(WORD_W))
            return CNT_W'(WORD_W);
        return req;
    endfunction

    // Switch word: enable first, then channel MSB first; zero when not programmable
    function automatic logic [MUX_W-1:0] mux_word(input logic              en,
                                                  input logic [CNT_W-1:0]  len,
                                                  input logic [CHAN_W-1:0] ch);
        if (en && len >= CNT_W'(MUX_W))
            return {1'b1, ch};
        return '0;
    endfunction

    function automatic rd_result_t unpack_word(input logic [WORD_W-1:0] w,
                                               input logic [CHAN_W-1:0] ch,
                                               input logic              trunc);
        rd_result_t r;
        r.eoc       = w[POS_EOC];
        r.test      = w[POS_TEST];
        r.sign      = w[POS_SIGN];
        r.range_ovr = w[POS_RANGE];
        r.data      = w[DATA_W-1:0];
        r.chan      = ch;
        r.trunc     = trunc;
        return r;
    endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
    parameter int               STAGES  = 2,
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              shift_en_i,
    input  logic [CNT_W-1:0]  idx_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_nxt_o
);
    logic [WORD_W-1:0] word_q;

    // Each bit position owns its own write select
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        localparam logic [CNT_W-1:0] SLOT = CNT_W'(WORD_W - 1 - b);
        assign word_nxt_o[b] = (shift_en_i && idx_i == SLOT) ? bit_i : word_q[b];
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            word_q <= '0;
        end else begin
            word_q <= word_nxt_o;
        end
    end
endmodule

// File: rtl/adc_rd_mux_tx.sv
module adc_rd_mux_tx #(
    parameter int MUX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [MUX_W-1:0] word_i,
    input  logic             adv_i,
    input  logic             clr_i,
    output logic             din_o
);
    logic [MUX_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= word_i;
        end else if (adv_i) begin
            sh_q <= {sh_q[MUX_W-2:0], 1'b0};
        end
    end

    assign din_o = sh_q[MUX_W-1];
endmodule

// File: rtl/adc_mux_reader.sv
module adc_mux_reader
    import adc_rd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CS_HIGH_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adc_sck_i,
    input  logic              adc_sdo_i,
    input  logic [CHAN_W-1:0] chan_req_i,
    input  logic              chan_en_i,
    input  logic [CNT_W-1:0]  rd_len_i,
    output logic              adc_cs_o,
    output logic              mux_cs_o,
    output logic              mux_din_o,
    output logic              res_valid_o,
    output logic              res_eoc_o,
    output logic              res_test_o,
    output logic              res_sign_o,
    output logic              res_range_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic [CHAN_W-1:0] res_chan_o,
    output logic              res_trunc_o
);
    // Cycles after select falls before the data line is trusted again
    localparam int GUARD   = SYNC_STAGES + 1;
    localparam int TMR_MAX = (CS_HIGH_CYC > GUARD) ? CS_HIGH_CYC : GUARD;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    logic [1:0]        sync_q;
    logic              sck_sy, sdo_sy, sck_d, sck_rise;
    rd_state_e         state_q;
    logic [CNT_W-1:0]  bit_cnt_q, len_q;
    logic [TMR_W-1:0]  tmr_q;
    logic [CHAN_W-1:0] conv_chan_q, pend_chan_q;
    logic              pend_ok_q;
    logic              adc_cs_q, mux_cs_q, valid_q;
    rd_result_t        res_q;
    logic              start, finish, shift_en;
    logic [CNT_W-1:0]  req_len;
    logic [MUX_W-1:0]  req_word;
    logic [WORD_W-1:0] word_nxt;

    adc_rd_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (2),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({adc_sck_i, adc_sdo_i}),
        .q_o (sync_q)
    );

    assign sck_sy = sync_q[1];
    assign sdo_sy = sync_q[0];

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b1;
        else     sck_d <= sck_sy;
    end

    assign sck_rise = sck_sy && !sck_d;
    assign req_len  = eff_len(rd_len_i);
    assign req_word = mux_word(chan_en_i, req_len, chan_req_i);
    assign start    = (state_q == ST_WAIT) && (tmr_q >= TMR_W'(GUARD)) && !sdo_sy;
    assign shift_en = (state_q == ST_READ) && sck_rise;
    assign finish   = shift_en && (bit_cnt_q == len_q - CNT_W'(1));

    adc_rd_capture #(
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) u_capture (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (state_q == ST_WAIT),
        .shift_en_i (shift_en),
        .idx_i      (bit_cnt_q),
        .bit_i      (sdo_sy),
        .word_nxt_o (word_nxt)
    );

    adc_rd_mux_tx #(
        .MUX_W (MUX_W)
    ) u_mux_tx (
        .clk    (clk),
        .rst    (rst),
        .load_i (start),
        .word_i (req_word),
        .adv_i  (shift_en),
        .clr_i  (finish),
        .din_o  (mux_din_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_WAIT;
            bit_cnt_q   <= '0;
            len_q       <= CNT_W'(WORD_W);
            tmr_q       <= '0;
            conv_chan_q <= '0;
            pend_chan_q <= '0;
            pend_ok_q   <= 1'b0;
            adc_cs_q    <= 1'b0;
            mux_cs_q    <= 1'b1;
            valid_q     <= 1'b0;
            res_q       <= '0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                ST_WAIT: begin
                    if (start) begin
                        state_q     <= ST_READ;
                        bit_cnt_q   <= '0;
                        len_q       <= req_len;
                        pend_chan_q <= chan_req_i;
                        pend_ok_q   <= req_word[MUX_W-1];
                    end else if (tmr_q < TMR_W'(GUARD)) begin
                        tmr_q <= tmr_q + TMR_W'(1);
                    end
                end
                ST_READ: begin
                    if (shift_en) begin
                        bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                    end
                    if (finish) begin
                        state_q  <= ST_HOLD;
                        tmr_q    <= '0;
                        adc_cs_q <= 1'b1;
                        mux_cs_q <= 1'b0;
                        valid_q  <= 1'b1;
                        res_q    <= unpack_word(word_nxt, conv_chan_q,
                                                len_q != CNT_W'(WORD_W));
                        if (pend_ok_q) conv_chan_q <= pend_chan_q;
                    end
                end
                ST_HOLD: begin
                    if (tmr_q == TMR_W'(CS_HIGH_CYC - 1)) begin
                        state_q  <= ST_WAIT;
                        tmr_q    <= '0;
                        adc_cs_q <= 1'b0;
                        mux_cs_q <= 1'b1;
                    end else begin
                        tmr_q <= tmr_q + TMR_W'(1);
                    end
                end
                default: state_q <= ST_WAIT;
            endcase
        end
    end

    assign adc_cs_o    = adc_cs_q;
    assign mux_cs_o    = mux_cs_q;
    assign res_valid_o = valid_q;
    assign res_eoc_o   = res_q.eoc;
    assign res_test_o  = res_q.test;
    assign res_sign_o  = res_q.sign;
    assign res_range_o = res_q.range_ovr;
    assign res_data_o  = res_q.data;
    assign res_chan_o  = res_q.chan;
    assign res_trunc_o = res_q.trunc;
endmodule

// File: rtl/adc_mux_reader_chk.sv
module adc_mux_reader_chk #(
    parameter int DATA_W = 28,
    parameter int CHAN_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_cs,
    input logic              mux_cs,
    input logic              mux_din,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic [CHAN_W-1:0] res_chan,
    input logic              sck_sync
);
    // R4: select only rises right after a high synchronized clock
    a_r4_cs_rise_sck_high: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs) |-> $past(sck_sync))
        else $error("a_r4_cs_rise_sck_high");

    // R4: select stays high beyond its rising cycle
    a_r4_cs_min_high: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs) |=> adc_cs)
        else $error("a_r4_cs_min_high");

    // R5: strobe coincides with select rising
    a_r5_valid_with_cs: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $rose(adc_cs))
        else $error("a_r5_valid_with_cs");

    // R5: strobe lasts one cycle
    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid)
        else $error("a_r5_valid_pulse");

    // R6: switch data quiet while the converter is deselected
    a_r6_din_idle: assert property (@(posedge clk) disable iff (rst)
        adc_cs |-> !mux_din)
        else $error("a_r6_din_idle");

    // R7: selects are complementary
    a_r7_mux_cs_inverse: assert property (@(posedge clk) disable iff (rst)
        mux_cs != adc_cs)
        else $error("a_r7_mux_cs_inverse");

    // R10: result held between strobes
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> ($stable(res_data) && $stable(res_chan)))
        else $error("a_r10_hold");
endmodule

bind adc_mux_reader adc_mux_reader_chk #(
    .DATA_W (adc_rd_pkg::DATA_W),
    .CHAN_W (adc_rd_pkg::CHAN_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .adc_cs    (adc_cs_o),
    .mux_cs    (mux_cs_o),
    .mux_din   (mux_din_o),
    .res_valid (res_valid_o),
    .res_data  (res_data_o),
    .res_chan  (res_chan_o),
    .sck_sync  (sck_sy)
);

// File: tb/adc_mux_reader_tb.sv
module adc_mux_reader_tb;
    localparam int CS_HIGH = 4;
    localparam int HALF    = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b1;
    logic        sdo = 1'b1;
    logic [2:0]  chan_req = 3'd0;
    logic        chan_en  = 1'b0;
    logic [5:0]  rd_len   = 6'd32;
    logic        adc_cs, mux_cs, mux_din, res_valid;
    logic        res_eoc, res_test, res_sign, res_range, res_trunc;
    logic [27:0] res_data;
    logic [2:0]  res_chan;

    int checks = 0;
    int errors = 0;
    int vcnt   = 0;
    logic        cap_cs, cap_mcs, cap_eoc, cap_test, cap_sign, cap_range, cap_trunc;
    logic [27:0] cap_data;
    logic [2:0]  cap_chan;
    logic [2:0]  model_chan = 3'd0;

    always #5 clk = ~clk;

    adc_mux_reader u_dut (
        .clk         (clk),
        .rst         (rst),
        .adc_sck_i   (sck),
        .adc_sdo_i   (sdo),
        .chan_req_i  (chan_req),
        .chan_en_i   (chan_en),
        .rd_len_i    (rd_len),
        .adc_cs_o    (adc_cs),
        .mux_cs_o    (mux_cs),
        .mux_din_o   (mux_din),
        .res_valid_o (res_valid),
        .res_eoc_o   (res_eoc),
        .res_test_o  (res_test),
        .res_sign_o  (res_sign),
        .res_range_o (res_range),
        .res_data_o  (res_data),
        .res_chan_o  (res_chan),
        .res_trunc_o (res_trunc)
    );

    always @(negedge clk) begin
        if (!rst && res_valid) begin
            vcnt      = vcnt + 1;
            cap_cs    = adc_cs;
            cap_mcs   = mux_cs;
            cap_eoc   = res_eoc;
            cap_test  = res_test;
            cap_sign  = res_sign;
            cap_range = res_range;
            cap_data  = res_data;
            cap_chan  = res_chan;
            cap_trunc = res_trunc;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 adc_cs in reset", 64'(adc_cs), 64'd0);
        chk("R1 mux_cs in reset", 64'(mux_cs), 64'd1);
        chk("R1 mux_din in reset", 64'(mux_din), 64'd0);
        chk("R1 valid in reset", 64'(res_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 adc_cs after reset", 64'(adc_cs), 64'd0);
    endtask

    // One conversion: converter model plus switch model plus checks
    task automatic do_read(input logic [2:0] ch, input logic en, input logic [5:0] len,
                           input logic sgn, input logic rng, input logic [24:0] pat,
                           input string tag);
        int          n_eff;
        int          edges;
        int          base;
        int          hi;
        bit          stop;
        bit          early;
        logic [31:0] word;
        logic [31:0] exp_word;
        logic [31:0] din_rec;
        logic [31:0] din_exp;
        logic [3:0]  exp_mux;
        logic [2:0]  new_chan;

        n_eff    = (len == 6'd0 || len > 6'd32) ? 32 : int'(len);
        word     = {1'b0, 1'b0, sgn, rng, model_chan, pat};
        exp_word = word & ~(32'hFFFF_FFFF >> n_eff);
        exp_mux  = (en && n_eff >= 4) ? {1'b1, ch} : 4'b0000;
        edges = 0; stop = 0; early = 0; din_rec = '0; din_exp = '0;
        base  = vcnt;
        new_chan = model_chan;

        @(negedge clk);
        chan_req = ch; chan_en = en; rd_len = len;
        repeat (20) @(negedge clk);
        sdo = 1'b0;
        repeat (6) @(negedge clk);
        // R2: request changes after the start must not matter
        chan_req = ~ch; chan_en = ~en; rd_len = 6'd2;

        for (int i = 0; i < 32 && !stop; i++) begin
            sck = 1'b0;
            sdo = word[31-i];
            for (int j = 0; j < HALF; j++) begin
                @(negedge clk);
                if (adc_cs) early = 1;
            end
            sck = 1'b1;
            din_rec[i] = mux_din;
            if (i < 4) din_exp[i] = exp_mux[3-i];
            edges++;
            for (int j = 0; j < HALF && !stop; j++) begin
                @(negedge clk);
                if (adc_cs) stop = 1;
            end
        end
        sdo = 1'b1;

        chk({"R4 no select rise in low clock phase ", tag}, 64'(early), 64'd0);
        chk({"R4 edges read ", tag}, 64'(edges), 64'(n_eff));
        chk({"R4 select raised ", tag}, 64'(stop), 64'd1);

        hi = 0;
        while (adc_cs && hi < 100) begin
            hi++;
            @(negedge clk);
        end
        chk({"R4 select high cycles ", tag}, 64'(hi), 64'(CS_HIGH));

        if (exp_mux == 4'b0000)
            chk({"R8 switch data held low ", tag}, 64'(din_rec), 64'(din_exp));
        else
            chk({"R6 switch word ", tag}, 64'(din_rec), 64'(din_exp));
        if (edges >= 4 && din_rec[0]) new_chan = {din_rec[1], din_rec[2], din_rec[3]};

        chk({"R5 one strobe ", tag}, 64'(vcnt - base), 64'd1);
        chk({"R5 strobe with select high ", tag}, 64'(cap_cs), 64'd1);
        chk({"R7 switch select inverse ", tag}, 64'(cap_mcs), 64'd0);
        chk({"R3 magnitude ", tag}, 64'(cap_data), 64'(exp_word[27:0]));
        chk({"R3 sign/range/test/eoc ", tag},
            64'({cap_eoc, cap_test, cap_sign, cap_range}), 64'(exp_word[31:28]));
        chk({"R5 trunc ", tag}, 64'(cap_trunc), 64'(n_eff != 32));
        chk({"R9 result channel ", tag}, 64'(cap_chan), 64'(model_chan));
        if (exp_mux == 4'b0000)
            chk({"R8 channel kept ", tag}, 64'(new_chan), 64'(model_chan));
        model_chan = new_chan;

        repeat (5) @(negedge clk);
        chk({"R10 result held ", tag}, 64'({res_data, res_chan}), 64'({cap_data, cap_chan}));
        chan_req = ch; chan_en = en; rd_len = len;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (all requirements) actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        test_reset();
        do_read(3'd3, 1'b1, 6'd32, 1'b0, 1'b1, 25'h1A5_5A5A, "full ch0");
        do_read(3'd5, 1'b1, 6'd32, 1'b1, 1'b0, 25'h0F0_F0F1, "full ch3");
        do_read(3'd6, 1'b1, 6'd12, 1'b1, 1'b1, 25'h1FF_FFFF, "abort 12");
        do_read(3'd2, 1'b0, 6'd32, 1'b0, 1'b0, 25'h123_4567, "enable off");
        do_read(3'd1, 1'b1, 6'd3,  1'b1, 1'b1, 25'h0AA_AAAA, "len 3");
        do_read(3'd4, 1'b1, 6'd0,  1'b0, 1'b1, 25'h155_5555, "len 0");
        do_read(3'd7, 1'b1, 6'd1,  1'b1, 1'b0, 25'h0C3_C3C3, "len 1");
        do_read(3'd0, 1'b1, 6'd4,  1'b0, 1'b0, 25'h1E1_E1E1, "len 4");
        do_read(3'd3, 1'b1, 6'd40, 1'b1, 1'b1, 25'h076_5432, "len 40");
        do_read(3'd2, 1'b1, 6'd31, 1'b0, 1'b1, 25'h1FF_FFFE, "len 31");
        summary();
        $finish;
    end
endmodule